// File: doc/BRIEF.md
# Multiprocessor-Addressed UART Receiver

This block is an asynchronous serial receiver with a small register file, and it gates its own interrupt requests. Each frame has one start bit and eight data bits, sent least significant bit first. In multiprocessor format an extra flag bit follows the data; it marks the frame as an address frame (1) or a data frame (0). One stop bit ends the frame. The line is sampled at the middle of each bit using a fixed 16x oversampling tick, and a clock divider parameter sets the rate of that tick.

Software can arm a wake-up bit. While the bit is armed, the receiver silently discards data frames and leaves all status flags untouched. The first address frame clears the wake-up bit in hardware. That frame is delivered as usual and normal reception resumes. This lets a node ignore traffic meant for other nodes until it is addressed again. The block has no transmit datapath. It only gates the transmit-empty and transmit-end requests that an external transmitter reports.

Top module: `mpuart_rx`

## Requirements
- R1: Register 1 (control) has six read/write bits, and all of them reset to 0: bit0 receive enable, bit1 receive interrupt enable, bit2 wake-up enable, bit3 transmit enable, bit4 transmit-empty interrupt enable, bit5 transmit-end interrupt enable. Bits 7:6 read 0.
- R2: Register 0 (mode) holds bit6 = multiprocessor format and bit7 = synchronous mode. A frame is 11 bits long with the format bit set and 10 bits long without it. Each received byte appears in register 3 (data). Register 2 (status) holds bit0 receive-full, bit1 overrun, bit2 framing error and bit3 last multiprocessor bit.
- R3: While wake-up is in effect, a frame whose multiprocessor bit is 0 is dropped. It sets none of receive-full, framing error or overrun, and it leaves the data register unchanged.
- R4: While wake-up is in effect, a frame whose multiprocessor bit is 1 clears the wake-up bit and is delivered normally.
- R5: With multiprocessor format off, the wake-up bit has no effect. Frames are delivered, and the bit keeps the value software wrote.
- R6: Wake-up written to 1 in the middle of a frame does not apply to that frame. It applies from the next start bit.
- R7: A delivered frame whose stop bit is sampled as 0 sets the framing-error flag.
- R8: A frame that completes while receive-full is still set sets overrun and does not overwrite the data register.
- R9: No frame is received while receive enable is 0 or synchronous mode is 1.
- R10: irq_rx_full equals receive-full AND receive interrupt enable. irq_rx_err equals (overrun OR framing error) AND receive interrupt enable.
- R11: irq_tx_empty equals tx_empty AND its enable (bit4). irq_tx_end equals tx_done AND its enable (bit5).
- R12: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear of receive-full lands in the cycle a frame completes, the clear is applied first: the frame is stored, receive-full stays 1 and overrun stays 0.
- R13: After reset all registers read 0 and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 mode, 1 control, 2 status, 3 data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| tx_empty | input | 1 | Transmit buffer empty, from an external transmitter |
| tx_done | input | 1 | Transmission finished, from an external transmitter |
| irq_rx_full | output | 1 | Receive-data-full request |
| irq_rx_err | output | 1 | Receive error request |
| irq_tx_empty | output | 1 | Transmit-empty request |
| irq_tx_end | output | 1 | Transmit-end request |

## Verification
A software clear of receive-full can fall in the same cycle that a frame completes. Whether the result is a clean delivery or an overrun depends on which of the two wins. The bench first measures the number of cycles from start-bit launch to the receive request. It then launches a second frame while receive-full is still set, and holds a one-cycle clear write across exactly that completion edge. The result is judged correct if the new byte is in the data register, receive-full is 1 and overrun is 0.

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DIV = 4,
  parameter int OVS = 16,
  parameter int DW  = 8
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_empty,
  input  logic       tx_done,
  output logic       irq_rx_full,
  output logic       irq_rx_err,
  output logic       irq_tx_empty,
  output logic       irq_tx_end
);
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int OW   = $clog2(OVS);
  localparam int BW   = $clog2(DW + 2);
  localparam int HALF = OVS / 2 - 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_st_t;

  logic          mode_mpf, mode_sync;
  logic [5:0]    ctrl_q;
  logic          rx_full, ovr, ferr, mpb;
  logic [DW-1:0] data_q;
  logic [1:0]    rx_sync;
  logic [PW-1:0] pcnt;
  rx_st_t        st;
  logic [OW-1:0] phase;
  logic [BW-1:0] bitn;
  logic [DW:0]   shreg;
  logic          arm_q, mpf_q;

  wire rx_s     = rx_sync[1];
  wire tick     = (pcnt == PW'(DIV - 1));
  wire rx_run   = ctrl_q[0] & ~mode_sync;
  wire wake_eff = ctrl_q[2] & mode_mpf & ~mode_sync;
  wire [BW-1:0] last_bit = mpf_q ? BW'(DW + 1) : BW'(DW);

  wire done = rx_run & tick & (st == S_BITS) & (phase == OW'(OVS - 1)) & (bitn == last_bit);
  wire [DW-1:0] fbyte = mpf_q ? shreg[DW-1:0] : shreg[DW:1];
  wire fmp      = mpf_q & shreg[DW];
  wire deliver  = done & ~(arm_q & ~fmp);
  wire wake_hit = done & arm_q & fmp;

  wire wr_ctrl  = reg_we & (reg_addr == 2'd1);
  wire wr_stat  = reg_we & (reg_addr == 2'd2);
  wire clr_full = wr_stat & reg_wdata[0];
  wire full_eff = rx_full & ~clr_full;

  assign irq_rx_full  = ctrl_q[1] & rx_full;
  assign irq_rx_err   = ctrl_q[1] & (ovr | ferr);
  assign irq_tx_empty = ctrl_q[4] & tx_empty;
  assign irq_tx_end   = ctrl_q[5] & tx_done;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {mode_sync, mode_mpf, 6'b0};
      2'd1:    reg_rdata = {2'b0, ctrl_q};
      2'd2:    reg_rdata = {4'b0, mpb, ferr, ovr, rx_full};
      default: reg_rdata = 8'(data_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      pcnt    <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      pcnt    <= tick ? '0 : pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      phase <= '0;
      bitn  <= '0;
      shreg <= '0;
      arm_q <= 1'b0;
      mpf_q <= 1'b0;
    end else if (!rx_run) begin
      st <= S_IDLE;
    end else if (tick) begin
      case (st)
        S_IDLE:
          if (!rx_s) begin
            st    <= S_START;
            phase <= '0;
          end
        S_START:
          if (phase == OW'(HALF)) begin
            if (rx_s) st <= S_IDLE;
            else begin
              st    <= S_BITS;
              phase <= '0;
              bitn  <= '0;
              arm_q <= wake_eff;
              mpf_q <= mode_mpf;
            end
          end else phase <= phase + 1'b1;
        S_BITS:
          if (phase == OW'(OVS - 1)) begin
            phase <= '0;
            if (bitn == last_bit) st <= S_IDLE;
            else begin
              shreg <= {rx_s, shreg[DW:1]};
              bitn  <= bitn + 1'b1;
            end
          end else phase <= phase + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_mpf  <= 1'b0;
      mode_sync <= 1'b0;
      ctrl_q    <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd0) begin
        mode_mpf  <= reg_wdata[6];
        mode_sync <= reg_wdata[7];
      end
      if (wr_ctrl) ctrl_q <= reg_wdata[5:0];
      if (wake_hit) ctrl_q[2] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      ferr    <= 1'b0;
      mpb     <= 1'b0;
      data_q  <= '0;
    end else begin
      rx_full <= deliver | full_eff;
      ovr     <= (deliver & full_eff) | (ovr & ~(wr_stat & reg_wdata[1]));
      ferr    <= (deliver & ~full_eff & ~rx_s) | (ferr & ~(wr_stat & reg_wdata[2]));
      if (deliver && !full_eff) begin
        data_q <= fbyte;
        mpb    <= fmp;
      end else if (wr_stat && reg_wdata[3]) mpb <= 1'b0;
    end
  end
endmodule

module mpuart_rx_chk #(
  parameter int DW = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          deliver,
  input logic          wake_hit,
  input logic          full_eff,
  input logic          stop_s,
  input logic          re,
  input logic          wake,
  input logic          rx_full,
  input logic          ovr,
  input logic          ferr,
  input logic [DW-1:0] data_q
);
  p_drop_keeps_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !deliver) |=> $stable(data_q));

  p_drop_no_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !deliver && !ovr) |=> !ovr);

  p_wake_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> !wake);

  p_ferr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && !full_eff && !stop_s) |=> ferr);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && full_eff) |=> (ovr && rx_full && $stable(data_q)));

  p_no_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> !$rose(rx_full));
endmodule

bind mpuart_rx mpuart_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .deliver(deliver),
  .wake_hit(wake_hit), .full_eff(full_eff), .stop_s(rx_s),
  .re(ctrl_q[0]), .wake(ctrl_q[2]), .rx_full(rx_full), .ovr(ovr),
  .ferr(ferr), .data_q(data_q)
);

// File: tb/mpuart_rx_test.sv
module mpuart_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic tx_empty = 1'b0, tx_done = 1'b0;
  logic irq_rx_full, irq_rx_err, irq_tx_empty, irq_tx_end;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mpuart_rx #(.DIV(1)) uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_empty(tx_empty), .tx_done(tx_done),
    .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err),
    .irq_tx_empty(irq_tx_empty), .irq_tx_end(irq_tx_end)
  );

  // {mpf, wake, byte, mp, stop, exp_full, exp_data, exp_ferr, exp_wake}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h3D, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h81, 1'b1, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'hC3, 1'b1, 1'b0, 1'b1, 8'hC3, 1'b1, 1'b0}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(logic [7:0] b, logic mp, logic stp, logic mpf);
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (16) @(negedge clk);
    end
    if (mpf) begin
      rxd = mp;
      repeat (16) @(negedge clk);
    end
    rxd = stp;
    repeat (stp ? 16 : 11) @(negedge clk);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R13 register", v, 0);
    end
    check("R13 irqs", {irq_rx_full, irq_rx_err, irq_tx_empty, irq_tx_end}, 0);

    // R1 control readback
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R1 all set", v, 8'h3F);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R1 all clear", v, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [22:0] t;
      t = VEC[i];
      wr(2'd2, 8'h0F);
      wr(2'd0, {1'b0, t[22], 6'b0});
      wr(2'd1, {5'b0, t[21], 2'b01});
      send(t[20:13], t[12], t[11], t[22]);
      rd(2'd2, v);
      check({vtag(i), " full"}, v[0], t[10]);
      check({vtag(i), " ferr"}, v[2], t[1]);
      rd(2'd3, v);
      check({vtag(i), " data"}, v, t[9:2]);
      rd(2'd1, v);
      check({vtag(i), " wake"}, v[2], t[0]);
    end

    // R10 gating: full and ferr are set now
    wr(2'd1, 8'h01);
    check("R10 rx gated off", {irq_rx_full, irq_rx_err}, 0);
    wr(2'd1, 8'h03);
    check("R10 rx gated on", {irq_rx_full, irq_rx_err}, 3);

    // R8 overrun
    wr(2'd0, 8'h40);
    send(8'h11, 1'b1, 1'b1, 1'b1);
    rd(2'd2, v); check("R8 overrun flag", v[1], 1);
    rd(2'd3, v); check("R8 data kept", v, 8'hC3);

    // R12 selective clear
    wr(2'd2, 8'h02);
    rd(2'd2, v); check("R12 clear ovr only", v[2:0], 3'b101);

    // R3 armed drop with full set: no overrun
    wr(2'd1, 8'h07);
    send(8'h22, 1'b0, 1'b1, 1'b1);
    rd(2'd2, v); check("R3 no ovr on drop", v[1], 0);
    rd(2'd3, v); check("R3 data kept", v, 8'hC3);
    wr(2'd2, 8'h0F);
    rd(2'd2, v); check("R12 clear all", v, 0);

    // R11 transmit gating
    wr(2'd1, 8'h00);
    tx_empty = 1'b1; tx_done = 1'b1;
    #1 check("R11 both off", {irq_tx_empty, irq_tx_end}, 0);
    wr(2'd1, 8'h10);
    check("R11 empty on", {irq_tx_empty, irq_tx_end}, 2);
    wr(2'd1, 8'h30);
    check("R11 both on", {irq_tx_empty, irq_tx_end}, 3);
    tx_empty = 1'b0;
    #1 check("R11 empty low", {irq_tx_empty, irq_tx_end}, 1);
    tx_done = 1'b0;

    // R9 receive disabled / sync mode
    wr(2'd1, 8'h00);
    send(8'h66, 1'b1, 1'b1, 1'b1);
    rd(2'd2, v); check("R9 re off", v[0], 0);
    wr(2'd0, 8'hC0);
    wr(2'd1, 8'h01);
    send(8'h67, 1'b1, 1'b1, 1'b1);
    rd(2'd2, v); check("R9 sync mode", v[0], 0);
    wr(2'd0, 8'h40);

    // R6 wake written mid-frame
    wr(2'd1, 8'h01);
    fork
      send(8'h42, 1'b0, 1'b1, 1'b1);
      begin
        repeat (60) @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h05;
        @(negedge clk);
        reg_we = 1'b0;
      end
    join
    rd(2'd2, v); check("R6 frame in flight kept", v[0], 1);
    rd(2'd3, v); check("R6 data", v, 8'h42);
    wr(2'd2, 8'h0F);
    send(8'h43, 1'b0, 1'b1, 1'b1);
    rd(2'd2, v); check("R6 next frame dropped", v[0], 0);

    // R12 clear coinciding with completion
    wr(2'd1, 8'h03);
    n = 0;
    fork
      send(8'h10, 1'b1, 1'b1, 1'b1);
      begin
        while (!irq_rx_full) begin
          @(negedge clk);
          n++;
        end
      end
    join
    fork
      send(8'h20, 1'b1, 1'b1, 1'b1);
      begin
        repeat (n - 1) @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
        @(negedge clk);
        reg_we = 1'b0;
      end
    join
    rd(2'd2, v); check("R12 same-cycle full", v[0], 1);
    check("R12 same-cycle no ovr", v[1], 0);
    rd(2'd3, v); check("R12 same-cycle data", v, 8'h20);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule